// File: doc/BRIEF.md
# Mode-0 SPI Port with Fault Detection

This block is a single SPI port that can run either as the clock-driving end of the link or as the selected end. It moves words of 1 to 16 bits. Software picks whether the most or the least significant bit goes out on the wire first. Whichever order is chosen, data in the registers is always right-aligned, and any unused upper bits read back as zero. Clock polarity and phase are fixed: data changes while the clock is low and is sampled on the rising edge. A small counter sets the length of each half period of the clock when the port drives it.

Software reaches the port through a plain word-wide register port with four addresses: control, transmit, receive and status. This port applies no back-pressure. A write or a read takes effect on the clock edge where its strobe is high, and read data is valid in the same cycle. The select input is also watched for faults. As the driving end, a low select aborts the current word. As the selected end, the select rising in the middle of a word marks a fault. Receive, overrun and fault flags are combined into one interrupt line.

Top module: `spi_mf_ctrl`

## Requirements
- R1: Control bit 2 sets the wire order. When it is 0, the first bit on the wire is bit len-1 of the word, in both directions. When it is 1, the first bit on the wire is bit 0.
- R2: Transmit and receive data sit right-aligned with their LSB at bit 0. Receive bits at len and above read as 0.
- R3: The length field is control bits 11:8 and holds len-1. The half period is (control bits 15:12) + 1 clock cycles. Writing the transmit register (address 1) when bit 0 (enable) and bit 1 (drive clock) are set and the port is idle sends exactly len clock pulses. While that happens, ss_n_o stays low.
- R4: Status bit 0 (word received) is set when a complete word enters the receive register (address 2). Only a read of address 2 clears it.
- R5: If a word completes while status bit 0 is still set, status bit 1 (overrun) is set and the receive register keeps its old word. Overrun clears on a receive read that follows a status read (address 3) which saw overrun set.
- R6: When the port drives the clock and control bit 4 (fault enable) is 1, a low ss_n_i aborts the current word. The clock returns low, ss_n_o goes high, no word is delivered, and status bit 2 (fault) is set. When fault enable is 0, ss_n_i is ignored in this role.
- R7: Clearing fault enable does not clear the fault flag. The flag clears only on a control write that follows a status read which saw the flag set.
- R8: In the selected role, ss_n_i rising in the middle of a word discards the partial word. This sets the fault flag only when fault enable is 1. The next word is received from its first bit.
- R9: irq is high when either of these holds: (received and control bit 5) is true, or (overrun or fault) and control bit 3 is true. This holds even with enable at 0.
- R10: After reset, control reads as 0 and all flags read as 0, with irq low, ss_n_o high and sclk_o low.
- R11: When a word completes in the same cycle as a receive read, the read returns the old word and the new word is loaded. Status bit 0 stays set and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (causes read side effects) |
| addr | input | 2 | 0 control, 1 transmit, 2 receive, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, valid in the same cycle |
| irq | output | 1 | Combined receive and error interrupt |
| sclk_o | output | 1 | Serial clock when driving |
| mosi_o | output | 1 | Serial data out when driving |
| ss_n_o | output | 1 | Select output, low during a driven word |
| miso_i | input | 1 | Serial data in when driving |
| sclk_i | input | 1 | Serial clock when selected |
| mosi_i | input | 1 | Serial data in when selected |
| ss_n_i | input | 1 | Select input and fault sense |
| miso_o | output | 1 | Serial data out when selected |

## Verification
The delicate overlap is a word completing in the same cycle that software reads the receive register. The bench starts a driven 4-bit word at half period 1. It then counts 2 x len cycles from the transmit write and raises the receive read strobe for exactly the completion edge. It checks that the old word came back on rdata, that the new word is in the register afterwards, and that the received flag is still set with no overrun. A second overlap is a fault arriving together with a control write that would clear it. This is covered by the rule that a set wins and by the sticky-flag assertion.

// File: rtl/spi_mf_pkg.sv
`timescale 1ns/1ps
package spi_mf_pkg;
  localparam int DW   = 16;  // register and maximum word width
  localparam int LW   = 4;   // bits of the length field
  localparam int DIVW = 4;   // bits of the half-period field

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TX   = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [DIVW-1:0] div;
    logic [LW-1:0]   len_m1;
    logic [1:0]      rsvd;
    logic            rx_ie;
    logic            flt_en;
    logic            err_ie;
    logic            lsb_first;
    logic            master;
    logic            enable;
  } ctrl_t;

  // position in the word of the bit travelling at step cnt
  function automatic logic [LW-1:0] bit_idx(input logic lsbf,
                                            input logic [LW-1:0] cnt,
                                            input logic [LW-1:0] len_m1);
    return lsbf ? cnt : (len_m1 - cnt);
  endfunction
endpackage

// File: rtl/spi_mf_sync.sv
`timescale 1ns/1ps
module spi_mf_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mf_engine.sv
`timescale 1ns/1ps
module spi_mf_engine
  import spi_mf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic          start_i,
  input  logic [DW-1:0] start_word_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          sclk_s,
  input  logic          ss_n_s,
  input  logic          mosi_s,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          ss_n_o,
  output logic          miso_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] done_data_o,
  output logic          fault_o
);
  logic            busy_q, sclk_q, sclk_d, ss_d, mid_q, wrap_q;
  logic [LW-1:0]   cnt_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   tx_sh_q, acc_q, acc_nx;
  logic [LW-1:0]   idx;
  logic            m_mode, s_mode, tick, s_rise, s_fall, last;
  logic            m_fault, s_fault, m_done, s_done, smp;
  logic            unused_ctrl;

  assign unused_ctrl = ^{ctrl.rsvd, ctrl.err_ie, ctrl.rx_ie};

  assign m_mode  = ctrl.enable & ctrl.master;
  assign s_mode  = ctrl.enable & ~ctrl.master;
  assign idx     = bit_idx(ctrl.lsb_first, cnt_q, ctrl.len_m1);
  assign tick    = (div_q == ctrl.div);
  assign s_rise  = sclk_s & ~sclk_d;
  assign s_fall  = ~sclk_s & sclk_d;
  assign last    = (cnt_q == ctrl.len_m1);
  assign smp     = ctrl.master ? miso_i : mosi_s;
  assign acc_nx  = acc_q | (DW'(smp) << idx);

  assign m_fault = m_mode & ctrl.flt_en & ~ss_n_s;
  assign s_fault = s_mode & ctrl.flt_en & ss_n_s & ~ss_d & mid_q;
  assign fault_o = m_fault | s_fault;

  assign m_done      = m_mode & busy_q & tick & sclk_q & last & ~m_fault;
  assign s_done      = s_mode & ~ss_n_s & s_rise & last;
  assign done_o      = m_done | s_done;
  assign done_data_o = m_done ? acc_q : acc_nx;

  assign sclk_o = sclk_q;
  assign ss_n_o = ~busy_q;
  assign mosi_o = busy_q & tx_sh_q[idx];
  assign miso_o = s_mode & ~ss_n_s & tx_word_i[idx];
  assign busy_o = busy_q | mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; sclk_d <= 1'b0; ss_d <= 1'b1;
      mid_q <= 1'b0; wrap_q <= 1'b0; cnt_q <= '0; div_q <= '0;
      tx_sh_q <= '0; acc_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_n_s;
      if (!ctrl.enable) begin
        busy_q <= 1'b0; sclk_q <= 1'b0; cnt_q <= '0; div_q <= '0;
        mid_q <= 1'b0; wrap_q <= 1'b0; acc_q <= '0;
      end else if (ctrl.master) begin
        mid_q <= 1'b0; wrap_q <= 1'b0;
        if (m_fault) begin
          busy_q <= 1'b0; sclk_q <= 1'b0; div_q <= '0;
        end else if (!busy_q) begin
          div_q <= '0; sclk_q <= 1'b0;
          if (start_i) begin
            busy_q <= 1'b1; cnt_q <= '0; tx_sh_q <= start_word_i; acc_q <= '0;
          end
        end else if (!tick) begin
          div_q <= div_q + 1'b1;
        end else begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            acc_q  <= acc_nx;
          end else begin
            sclk_q <= 1'b0;
            if (last) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + 1'b1;
          end
        end
      end else begin
        busy_q <= 1'b0; sclk_q <= 1'b0; div_q <= '0;
        if (ss_n_s) begin
          cnt_q <= '0; mid_q <= 1'b0; wrap_q <= 1'b0; acc_q <= '0;
        end else if (s_rise) begin
          if (last) begin
            acc_q <= '0; mid_q <= 1'b0; wrap_q <= 1'b1;
          end else begin
            acc_q <= acc_nx; mid_q <= 1'b1;
          end
        end else if (s_fall) begin
          if (wrap_q) begin
            cnt_q <= '0; wrap_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fault && busy_q) |=> (!busy_q && !sclk_q));

  // R2
  zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((done_data_o >> ({1'b0, ctrl.len_m1} + 5'd1)) == '0));
endmodule

// File: rtl/spi_mf_regs.sv
`timescale 1ns/1ps
module spi_mf_regs
  import spi_mf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] tx_word_o,
  output logic          start_o,
  output logic [DW-1:0] start_word_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] done_data_i,
  input  logic          fault_i,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] tx_q, rx_q;
  logic          sprf, ovrf, modf, ovr_arm, mod_arm;
  logic          ctrl_wr, stat_rd, rx_rd;

  assign ctrl_wr      = wr_en & (addr == A_CTRL);
  assign start_o      = wr_en & (addr == A_TX);
  assign stat_rd      = rd_en & (addr == A_STAT);
  assign rx_rd        = rd_en & (addr == A_RX);
  assign start_word_o = wdata;
  assign ctrl_o       = ctrl_q;
  assign tx_word_o    = tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; tx_q <= '0; rx_q <= '0;
      sprf <= 1'b0; ovrf <= 1'b0; modf <= 1'b0;
      ovr_arm <= 1'b0; mod_arm <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(wdata);
        if (mod_arm) begin modf <= 1'b0; mod_arm <= 1'b0; end
      end
      if (start_o) tx_q <= wdata;
      if (stat_rd) begin
        if (ovrf) ovr_arm <= 1'b1;
        if (modf) mod_arm <= 1'b1;
      end
      if (rx_rd) begin
        sprf <= 1'b0;
        if (ovr_arm) begin ovrf <= 1'b0; ovr_arm <= 1'b0; end
      end
      if (done_i) begin
        if (sprf && !rx_rd) ovrf <= 1'b1;
        else begin rx_q <= done_data_i; sprf <= 1'b1; end
      end
      if (fault_i) modf <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_TX:    rdata = tx_q;
      A_RX:    rdata = rx_q;
      default: rdata = {{(DW-4){1'b0}}, busy_i, modf, ovrf, sprf};
    endcase
  end

  assign irq_o = (sprf & ctrl_q.rx_ie) | (ctrl_q.err_ie & (ovrf | modf));

  // R4
  sprf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> sprf);

  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && sprf && !rx_rd) |=> (ovrf && $stable(rx_q)));

  // R7
  modf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !(ctrl_wr && mod_arm)) |=> modf);
endmodule

// File: rtl/spi_mf_ctrl.sv
`timescale 1ns/1ps
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          ss_n_o,
  input  logic          miso_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          ss_n_i,
  output logic          miso_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] tx_word, start_word, done_data;
  logic          start, busy, done, fault;
  logic [2:0]    pins_s;

  spi_mf_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sclk_i, mosi_i}), .q(pins_s));

  spi_mf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ctrl_o(ctrl), .tx_word_o(tx_word),
    .start_o(start), .start_word_o(start_word), .busy_i(busy),
    .done_i(done), .done_data_i(done_data), .fault_i(fault), .irq_o(irq));

  spi_mf_engine u_eng (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .start_i(start),
    .start_word_i(start_word), .tx_word_i(tx_word),
    .sclk_s(pins_s[1]), .ss_n_s(pins_s[2]), .mosi_s(pins_s[0]),
    .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o),
    .miso_o(miso_o), .busy_o(busy), .done_o(done), .done_data_o(done_data),
    .fault_o(fault));
endmodule

// File: tb/tb_spi_mf_ctrl.sv
`timescale 1ns/1ps
module tb_spi_mf_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic irq, sclk_o, mosi_o, ss_n_o, miso_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_mf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .ss_n_o(ss_n_o), .miso_i(mosi_o), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .ss_n_i(ss_n_i), .miso_o(miso_o));

  // wire monitor for the driving role
  logic mon_clr = 1'b0, sclk_prev = 1'b0, ssn_low_ok = 1'b1;
  logic [15:0] wire_bits = '0;
  int rises = 0;
  always @(negedge clk) begin
    if (mon_clr) begin
      wire_bits <= '0; rises <= 0; ssn_low_ok <= 1'b1;
    end else if (sclk_o && !sclk_prev) begin
      wire_bits <= {wire_bits[14:0], mosi_o};
      rises <= rises + 1;
      if (ss_n_o) ssn_low_ok <= 1'b0;
    end
    sclk_prev <= sclk_o;
  end

  // {lsb_first, len-1, div, tx}
  localparam logic [24:0] VEC [0:7] = '{
    {1'b0, 4'd15, 4'd0, 16'hA5C3},
    {1'b1, 4'd15, 4'd1, 16'hA5C3},
    {1'b0, 4'd7,  4'd2, 16'h12B4},
    {1'b1, 4'd7,  4'd0, 16'h00F1},
    {1'b0, 4'd0,  4'd0, 16'hFFFF},
    {1'b1, 4'd0,  4'd3, 16'h0001},
    {1'b0, 4'd11, 4'd1, 16'h8ABC},
    {1'b1, 4'd4,  4'd2, 16'h7FEE}
  };

  function automatic logic [15:0] mk_ctrl(bit en, bit mst, bit lsbf, bit errie,
                                          bit flten, bit rxie, int len_m1, int div);
    logic [15:0] c;
    c = '0;
    c[0] = en; c[1] = mst; c[2] = lsbf; c[3] = errie; c[4] = flten; c[5] = rxie;
    c[11:8] = 4'(len_m1); c[15:12] = 4'(div);
    return c;
  endfunction

  function automatic logic [15:0] lowmask(int len);
    return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd3, s);
      if (!s[3]) break;
    end
  endtask

  // selected-role word: nbits clocks, then select released
  task automatic slave_word(logic [15:0] d, bit lsbf, int len, int nbits,
                            output logic [15:0] cap);
    cap = '0;
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int ix;
      ix = lsbf ? i : (len - 1 - i);
      mosi_i = d[ix];
      repeat (4) @(negedge clk);
      cap[ix] = miso_o;
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    logic [15:0] r, exp_wire, cap;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 sclk_o", {15'd0, sclk_o}, 16'h0);
    check("R10 ss_n_o", {15'd0, ss_n_o}, 16'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, r); check("R10 ctrl", r, 16'h0000);
    rd(2'd3, r); check("R10 status", r, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'h0);

    // vector table: driven words looped back (R1 R2 R3 R4)
    foreach (VEC[v]) begin
      logic lsbf; int len, div; logic [15:0] tx;
      lsbf = VEC[v][24]; len = int'(VEC[v][23:20]) + 1;
      div = int'(VEC[v][19:16]); tx = VEC[v][15:0];
      wr(2'd0, mk_ctrl(1, 1, lsbf, 0, 0, 0, len - 1, div));
      mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
      wr(2'd1, tx);
      wait_idle();
      exp_wire = '0;
      for (int i = 0; i < len; i++)
        exp_wire[len - 1 - i] = lsbf ? tx[i] : tx[len - 1 - i];
      check("R1 wire order", wire_bits & lowmask(len), exp_wire);
      check("R3 clock count", 16'(rises), 16'(len));
      check("R3 select low", {15'd0, ssn_low_ok}, 16'h1);
      rd(2'd3, r); check("R4 received set", {15'd0, r[0]}, 16'h1);
      rd(2'd2, r); check("R2 right aligned", r, tx & lowmask(len));
      rd(2'd3, r); check("R4 read clears", {15'd0, r[0]}, 16'h0);
    end

    // R5 overrun, R9 interrupt
    wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 7, 0));
    wr(2'd1, 16'h0011); wait_idle();
    wr(2'd1, 16'h0022); repeat (40) @(negedge clk);
    check("R9 irq masked", {15'd0, irq}, 16'h0);
    wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 7, 0));
    check("R9 irq overrun", {15'd0, irq}, 16'h1);
    rd(2'd3, r); check("R5 overrun flags", r[2:0], 3'b011);
    rd(2'd2, r); check("R5 old word kept", r, 16'h0011);
    rd(2'd3, r); check("R5 overrun cleared", r[2:0], 3'b000);
    check("R9 irq low", {15'd0, irq}, 16'h0);
    wr(2'd1, 16'h0044); wait_idle();
    wr(2'd0, mk_ctrl(0, 1, 0, 0, 0, 1, 7, 0));
    check("R9 irq rx while disabled", {15'd0, irq}, 16'h1);
    rd(2'd2, r);
    check("R9 irq after read", {15'd0, irq}, 16'h0);

    // R11 completion in the same cycle as a receive read
    wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 3, 0));
    wr(2'd1, 16'h0005); wait_idle();
    wr(2'd1, 16'h000A);
    repeat (7) @(negedge clk);
    rd_en = 1'b1; addr = 2'd2; #1 r = rdata;
    @(negedge clk); rd_en = 1'b0;
    check("R11 read returns old", r, 16'h0005);
    rd(2'd3, r); check("R11 flags", r[2:0], 3'b001);
    rd(2'd2, r); check("R11 new word", r, 16'h000A);

    // R6 fault abort, R7 sticky
    wr(2'd0, mk_ctrl(1, 1, 0, 1, 1, 0, 15, 3));
    wr(2'd1, 16'hFFFF);
    repeat (20) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 select released", {15'd0, ss_n_o}, 16'h1);
    check("R6 clock low", {15'd0, sclk_o}, 16'h0);
    check("R6 irq fault", {15'd0, irq}, 16'h1);
    ss_n_i = 1'b1;
    repeat (160) @(negedge clk);
    wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 15, 3));
    check("R7 sticky irq", {15'd0, irq}, 16'h1);
    rd(2'd3, r); check("R6 R7 status", r[3:0], 4'b0100);
    wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 15, 3));
    rd(2'd3, r); check("R7 cleared", r[2:0], 3'b000);

    // R6 select ignored with fault enable 0
    wr(2'd0, mk_ctrl(1, 1, 0, 1, 0, 0, 7, 0));
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'h003C); wait_idle();
    rd(2'd3, r); check("R6 ignored status", r[2:0], 3'b001);
    rd(2'd2, r); check("R6 ignored data", r, 16'h003C);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);

    // R8 selected role
    wr(2'd0, mk_ctrl(1, 0, 1, 1, 1, 0, 7, 0));
    wr(2'd1, 16'h0096);
    slave_word(16'h005A, 1, 8, 8, cap);
    check("R1 slave out order", cap & 16'h00FF, 16'h0096);
    rd(2'd3, r); check("R8 full word no fault", r[2:0], 3'b001);
    rd(2'd2, r); check("R1 slave in order", r, 16'h005A);
    wr(2'd0, mk_ctrl(1, 0, 0, 1, 0, 0, 7, 0));
    slave_word(16'h00FF, 0, 8, 3, cap);
    rd(2'd3, r); check("R8 abort without enable", r[2:0], 3'b000);
    slave_word(16'h00C3, 0, 8, 8, cap);
    rd(2'd2, r); check("R8 next word clean", r, 16'h00C3);
    wr(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 7, 0));
    slave_word(16'h00FF, 0, 8, 5, cap);
    rd(2'd3, r); check("R8 abort with enable", r[2:0], 3'b100);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule